// File: doc/BRIEF.md
# Per-Task Return-Address Stack

This block keeps return addresses for a core that interleaves several hardware tasks. Each task owns a private last-in first-out store of four entries. A call strobe pushes the supplied absolute return address onto the stack of the task named on `task_id`. A return strobe, which serves both a subroutine return and an explicit pop into a general register, removes the top entry and reports it on `pop_data` one cycle later. When a stack is already full, a push drops the oldest entry silently, so the four most recent addresses remain retrievable in order. Popping an empty stack yields zero and raises a one-cycle underflow pulse.

The top entry of the selected task is also readable through a small register-read port. A read of the link-register address returns that entry without disturbing the stack, so the top of the stack can serve as a link register. A call followed by an explicit pop gives the same effect as a call that deposits its return address in a register. All outputs are registered. Every response appears in the cycle after its request and reflects the stack state before that cycle's update.

Top module: `rstk_task_lifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pop_valid`, `underflow` and `link_hit` are 0, and `pop_data` and `link_data` are 0. After reset every task's stack is empty.
- R2: A pop (`ret_en`=1, `call_en`=0) on a non-empty stack gives `pop_valid`=1 and `pop_data` equal to the most recently pushed, not yet popped, 17-bit address of that task, one cycle after the request. Entries come back in reverse push order.
- R3: After more than four pushes without pops, the four most recent addresses pop out newest first, and the next pop underflows. Older addresses are lost.
- R4: A pop on an empty stack gives `pop_valid`=0, `pop_data`=0 and `underflow`=1 one cycle later. `underflow` is 0 in the cycle after any cycle without a pop request, and the stack stays empty.
- R5: Pushes and pops act only on the stack of the task given by `task_id`. No other task's stack changes.
- R6: When `rd_en`=1 and `rd_addr`=0x1F1, the next cycle has `link_hit`=1 and `link_data` equal to the top entry of task `task_id`, as it was before any same-cycle push or pop. The stack is not popped. For any other `rd_addr`, or when `rd_en`=0, `link_hit`=0 and `link_data`=0.
- R7: A push and a pop for the same task in the same cycle replace the top entry with `call_addr`, and the entry count does not change. The old top is reported as a normal pop. On an empty stack the pop underflows and the new address becomes the only entry.
- R8: A link-register read of an empty stack gives `link_hit`=1 and `link_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_id | input | 2 | Task whose stack the request addresses |
| call_en | input | 1 | Push request |
| call_addr | input | 17 | Absolute return address to push |
| ret_en | input | 1 | Pop request (return or pop-to-register) |
| rd_en | input | 1 | Register-read request |
| rd_addr | input | 9 | Register address of the read |
| pop_valid | output | 1 | Popped entry on `pop_data` is valid |
| pop_data | output | 17 | Popped return address, zero on underflow |
| underflow | output | 1 | Pop hit an empty stack |
| link_hit | output | 1 | Previous read addressed the link register |
| link_data | output | 17 | Top entry of the read task, zero on a miss |

## Verification
The bench builds the block with its default values: four tasks, a depth of four and 17-bit addresses. With these values it can sweep every task with push runs of zero to six entries. That sweep reaches the empty, partly filled, exactly full and wrapped states of each stack. After each run it reads the link register for all four tasks, which shows that the other tasks stay untouched, and then drains the stack past empty into underflow. Directed sequences cover a push and pop in the same cycle on both a filled and an empty stack, a read at a neighbouring register address, and a read issued in the same cycle as a push.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned TASKS_DEF  = 4;
  localparam int unsigned DEPTH_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 17;
  localparam int unsigned REG_AW_DEF = 9;
  localparam logic [8:0]  LINK_REG_DEF = 9'h1F1;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_SWAP;
      default: return OP_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/rstk_lane.sv
module rstk_lane
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] top,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) slot[i] <= '0;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          slot[0] <= din;
          for (int i = 1; i < int'(DEPTH); i++) slot[i] <= slot[i-1];
          if (cnt_q != FULL) cnt_q <= cnt_q + ONE;
        end
        OP_POP: begin
          for (int i = 0; i < int'(DEPTH) - 1; i++) slot[i] <= slot[i+1];
          slot[DEPTH-1] <= '0;
          if (cnt_q != '0) cnt_q <= cnt_q - ONE;
        end
        OP_SWAP: begin
          slot[0] <= din;
          if (cnt_q == '0) cnt_q <= ONE;
        end
        default: ;
      endcase
    end
  end

  assign top = (cnt_q == '0) ? '0 : slot[0];
  assign cnt = cnt_q;
endmodule

// File: rtl/rstk_select.sv
module rstk_select #(
  parameter int unsigned TASKS  = 4,
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned TID_W  = 2
) (
  input  logic [ADDR_W-1:0] tops [TASKS],
  input  logic [CNT_W-1:0]  cnts [TASKS],
  input  logic [TID_W-1:0]  sel,
  output logic [ADDR_W-1:0] top,
  output logic              nonempty
);
  always_comb begin
    top      = '0;
    nonempty = 1'b0;
    for (int t = 0; t < int'(TASKS); t++) begin
      if (sel == TID_W'(t)) begin
        top      = tops[t];
        nonempty = (cnts[t] != '0);
      end
    end
  end
endmodule

// File: rtl/rstk_resp.sv
module rstk_resp #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned REG_AW   = 9,
  parameter logic [REG_AW-1:0] LINK_REG = 9'h1F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop_req,
  input  logic              rd_req,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              nonempty,
  input  logic [ADDR_W-1:0] top,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] pop_data,
  output logic              underflow,
  output logic              link_hit,
  output logic [ADDR_W-1:0] link_data
);
  logic hit;
  assign hit = rd_req && (rd_addr == LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_data  <= '0;
      underflow <= 1'b0;
      link_hit  <= 1'b0;
      link_data <= '0;
    end else begin
      pop_valid <= pop_req && nonempty;
      underflow <= pop_req && !nonempty;
      pop_data  <= (pop_req && nonempty) ? top : '0;
      link_hit  <= hit;
      link_data <= hit ? top : '0;
    end
  end
endmodule

// File: rtl/rstk_task_lifo.sv
module rstk_task_lifo
  import rstk_pkg::*;
#(
  parameter int unsigned TASKS    = TASKS_DEF,
  parameter int unsigned DEPTH    = DEPTH_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned REG_AW   = REG_AW_DEF,
  parameter logic [REG_AW-1:0] LINK_REG = LINK_REG_DEF,
  localparam int unsigned TID_W   = (TASKS > 1) ? $clog2(TASKS) : 1,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TID_W-1:0]  task_id,
  input  logic              call_en,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic              ret_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] pop_data,
  output logic              underflow,
  output logic              link_hit,
  output logic [ADDR_W-1:0] link_data
);
  logic [ADDR_W-1:0] lane_top [TASKS];
  logic [CNT_W-1:0]  lane_cnt [TASKS];
  logic [ADDR_W-1:0] sel_top;
  logic              sel_nonempty;
  stk_op_e           req_op;

  assign req_op = decode_op(call_en, ret_en);

  for (genvar t = 0; t < int'(TASKS); t++) begin : g_lane
    stk_op_e lane_op;
    assign lane_op = (task_id == TID_W'(t)) ? req_op : OP_IDLE;

    rstk_lane #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_lane (
      .clk(clk),
      .rst(rst),
      .op (lane_op),
      .din(call_addr),
      .top(lane_top[t]),
      .cnt(lane_cnt[t])
    );
  end

  rstk_select #(
    .TASKS (TASKS),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .TID_W (TID_W)
  ) u_select (
    .tops    (lane_top),
    .cnts    (lane_cnt),
    .sel     (task_id),
    .top     (sel_top),
    .nonempty(sel_nonempty)
  );

  rstk_resp #(
    .ADDR_W  (ADDR_W),
    .REG_AW  (REG_AW),
    .LINK_REG(LINK_REG)
  ) u_resp (
    .clk      (clk),
    .rst      (rst),
    .pop_req  (ret_en),
    .rd_req   (rd_en),
    .rd_addr  (rd_addr),
    .nonempty (sel_nonempty),
    .top      (sel_top),
    .pop_valid(pop_valid),
    .pop_data (pop_data),
    .underflow(underflow),
    .link_hit (link_hit),
    .link_data(link_data)
  );
endmodule

// File: rtl/rstk_task_lifo_chk.sv
module rstk_task_lifo_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned REG_AW = 9,
  parameter int unsigned TID_W  = 2,
  parameter logic [REG_AW-1:0] LINK_REG = 9'h1F1
) (
  input logic              clk,
  input logic              rst,
  input logic [TID_W-1:0]  task_id,
  input logic              call_en,
  input logic [ADDR_W-1:0] call_addr,
  input logic              ret_en,
  input logic              rd_en,
  input logic [REG_AW-1:0] rd_addr,
  input logic              pop_valid,
  input logic [ADDR_W-1:0] pop_data,
  input logic              underflow,
  input logic              link_hit,
  input logic [ADDR_W-1:0] link_data
);
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(pop_valid && underflow));

  p_underflow_zero_r4: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (pop_data == '0));

  p_pop_answers_r2: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> (pop_valid || underflow));

  p_no_pop_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !ret_en |=> (!pop_valid && !underflow));

  p_push_then_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (call_en && !ret_en) ##1 (ret_en && !call_en && task_id == $past(task_id))
      |=> (pop_valid && pop_data == $past(call_addr, 2)));

  p_link_miss_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_addr == LINK_REG) |=> (!link_hit && link_data == '0));

  p_link_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == LINK_REG) |=> link_hit);
endmodule

bind rstk_task_lifo rstk_task_lifo_chk #(
  .ADDR_W  (ADDR_W),
  .REG_AW  (REG_AW),
  .TID_W   (TID_W),
  .LINK_REG(LINK_REG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .task_id  (task_id),
  .call_en  (call_en),
  .call_addr(call_addr),
  .ret_en   (ret_en),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .pop_valid(pop_valid),
  .pop_data (pop_data),
  .underflow(underflow),
  .link_hit (link_hit),
  .link_data(link_data)
);

// File: tb/rstk_task_lifo_bench.sv
module rstk_task_lifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] LINK = 9'h1F1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  task_id = '0;
  logic        call_en = 1'b0;
  logic [16:0] call_addr = '0;
  logic        ret_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic        pop_valid, underflow, link_hit;
  logic [16:0] pop_data, link_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstk_task_lifo u_rstk_task_lifo (
    .clk(clk), .rst(rst), .task_id(task_id), .call_en(call_en),
    .call_addr(call_addr), .ret_en(ret_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .pop_valid(pop_valid), .pop_data(pop_data), .underflow(underflow),
    .link_hit(link_hit), .link_data(link_data)
  );

  function automatic logic [16:0] val(input int t, input int i);
    return 17'h10000 | 17'(t << 12) | 17'(i * 37 + 5);
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic r, input logic rd, input int tid,
                      input logic [16:0] a, input logic [8:0] ra);
    call_en = c; ret_en = r; rd_en = rd; task_id = tid[1:0]; call_addr = a; rd_addr = ra;
    @(negedge clk);
    call_en = 1'b0; ret_en = 1'b0; rd_en = 1'b0; call_addr = '0; rd_addr = '0;
  endtask

  task automatic expect_pop(input string req, input logic [16:0] exp);
    check({req, " pop_valid"}, 17'(pop_valid), 17'd1);
    check({req, " underflow"}, 17'(underflow), 17'd0);
    check({req, " pop_data"}, pop_data, exp);
  endtask

  task automatic expect_uf(input string req);
    check({req, " underflow"}, 17'(underflow), 17'd1);
    check({req, " pop_valid"}, 17'(pop_valid), 17'd0);
    check({req, " pop_data"}, pop_data, 17'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    check("R1 pop_valid", 17'(pop_valid), 17'd0);
    check("R1 underflow", 17'(underflow), 17'd0);
    check("R1 link_hit", 17'(link_hit), 17'd0);
    check("R1 pop_data", pop_data, 17'd0);
    check("R1 link_data", link_data, 17'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle pop_valid", 17'(pop_valid), 17'd0);
    for (int u = 0; u < 4; u++) begin
      step(0, 0, 1, u, '0, LINK);
      check("R8 empty link_hit", 17'(link_hit), 17'd1);
      check("R1 R8 empty link_data", link_data, 17'd0);
    end

    // Sweep: every task, runs of 0..6 pushes (R2 R3 R4 R5 R6)
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k <= 6; k++) begin
        for (int i = 0; i < k; i++) step(1, 0, 0, t, val(t, i), '0);
        for (int u = 0; u < 4; u++) begin
          step(0, 0, 1, u, '0, LINK);
          check("R6 link_hit", 17'(link_hit), 17'd1);
          check("R5 R6 link_data", link_data, (u == t && k > 0) ? val(t, k - 1) : 17'd0);
        end
        for (int j = 0; j < ((k < 4) ? k : 4); j++) begin
          step(0, 1, 0, t, '0, '0);
          expect_pop((k > 4) ? "R3" : "R2", val(t, k - 1 - j));
        end
        step(0, 1, 0, t, '0, '0);
        expect_uf((k > 4) ? "R3 R4" : "R4");
        step(0, 0, 0, t, '0, '0);
        check("R4 underflow one cycle", 17'(underflow), 17'd0);
      end
    end

    // R6: neighbouring address misses, stack untouched
    step(1, 0, 0, 0, 17'h1ABCD, '0);
    step(0, 0, 1, 0, '0, 9'h1F0);
    check("R6 miss link_hit", 17'(link_hit), 17'd0);
    check("R6 miss link_data", link_data, 17'd0);
    // R6: read in same cycle as a push sees old top
    step(1, 0, 1, 0, 17'h00042, LINK);
    check("R6 read with push", link_data, 17'h1ABCD);
    step(0, 1, 0, 0, '0, '0);
    expect_pop("R6 after read", 17'h00042);
    step(0, 1, 0, 0, '0, '0);
    expect_pop("R6 no pop by read", 17'h1ABCD);

    // R7: push+pop on filled stack
    step(1, 0, 0, 1, 17'h0AAAA, '0);
    step(1, 0, 0, 1, 17'h0BBBB, '0);
    step(1, 1, 0, 1, 17'h1CCCC, '0);
    expect_pop("R7 swap reports old top", 17'h0BBBB);
    step(0, 0, 1, 1, '0, LINK);
    check("R7 top replaced", link_data, 17'h1CCCC);
    step(0, 1, 0, 1, '0, '0);
    expect_pop("R7 new top", 17'h1CCCC);
    step(0, 1, 0, 1, '0, '0);
    expect_pop("R7 depth kept", 17'h0AAAA);
    step(0, 1, 0, 1, '0, '0);
    expect_uf("R7 drained");
    // R7: push+pop on empty stack
    step(1, 1, 0, 2, 17'h1DDDD, '0);
    expect_uf("R7 empty swap");
    step(0, 0, 1, 2, '0, LINK);
    check("R7 empty swap entry", link_data, 17'h1DDDD);
    step(0, 1, 0, 2, '0, '0);
    expect_pop("R7 sole entry", 17'h1DDDD);
    step(0, 1, 0, 2, '0, '0);
    expect_uf("R7 sole entry drained");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule